// File: doc/BRIEF.md
# Processor Bus Command Generator

This block sits beside a processor that announces each bus cycle with a three-bit status code. It turns that code into active-low command strobes for memory read and write, I/O read and write, early ("advanced") write variants of both, and interrupt acknowledge. It also produces an address latch pulse, a data direction level, a system data transceiver enable and one dual-purpose output.

A static mode strap chooses between two ways of working. With the strap low, every command waits for an arbitration grant: the active-low arbitration enable input must be sampled low on a fixed number of clocks in a row. With the strap high, I/O-class commands ignore arbitration and start at once, and a separate peripheral transceiver enable serves the I/O bus. Memory commands still wait for the grant. A command-enable input can hold off all strobes and enables.

All outputs are registered. The dual-purpose output is the only exception: the strap selects which registered enable it shows.

Top module: `bus_cmd_gen`

## Requirements
- R1: Status codes decode as follows. 000 gives interrupt acknowledge. 001 gives I/O read. 010 gives I/O write with advanced I/O write. 011 (halt) gives no command. 100 and 101 give memory read. 110 gives memory write with advanced memory write. 111 is passive and gives no command. At most one command class is active at a time.
- R2: While reset is high, on every clock edge all strobes go high (inactive), and addr_latch, data_en and the internal enables go low. dir_wr goes high. casc_pden reads 0 with io_mode low and 1 with io_mode high.
- R3: A bus cycle starts on the first clock edge where the status is not 111 and the block is idle. addr_latch is high for exactly the clock after that edge, whatever the arbitration input does.
- R4: Read strobes, interrupt acknowledge and the advanced write strobes may assert from the edge after cycle start. The normal write strobes may assert one edge later. An active normal write always has its advanced write active too.
- R5: On the first clock edge that samples status 111, every strobe deasserts and the block goes idle.
- R6: With io_mode low, a strobe may assert on an edge only if arb_en_n was sampled low on each of the ARB_DELAY preceding edges (default 2). Sampling arb_en_n high drops the grant, and active strobes deassert on the next edge.
- R7: With io_mode high, I/O read, I/O write, advanced I/O write and interrupt acknowledge ignore arb_en_n. Memory strobes still obey the R6 grant.
- R8: casc_pden is an active-high cascade enable while io_mode is low, high during interrupt acknowledge timed with its strobe. While io_mode is high, it is an active-low peripheral data enable, low while an I/O-class command is active.
- R9: dir_wr is low from the cycle start edge through the cycle for codes 000, 001, 100 and 101. It is high otherwise, including during write cycles.
- R10: data_en is high exactly while a command is active. The exception is I/O-class commands with io_mode high: these use the peripheral enable instead, and data_en stays low.
- R11: Sampling cmd_en low makes every strobe, data_en and the dual enable inactive after that edge. It has no effect on addr_latch or dir_wr.
- R12: A halt cycle (011) pulses addr_latch and asserts no strobe and no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_i | input | 3 | Processor status code |
| arb_en_n | input | 1 | Arbitration enable, low when the bus is granted |
| io_mode | input | 1 | Mode strap: 0 system-bus, 1 I/O-bus |
| cmd_en | input | 1 | Command enable, high allows strobes |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| adv_mem_wr_n | output | 1 | Advanced memory write strobe, active low |
| adv_io_wr_n | output | 1 | Advanced I/O write strobe, active low |
| int_ack_n | output | 1 | Interrupt acknowledge strobe, active low |
| addr_latch | output | 1 | Address latch pulse, active high |
| dir_wr | output | 1 | Data direction, high for write |
| data_en | output | 1 | System data transceiver enable, active high |
| casc_pden | output | 1 | Cascade enable (io_mode 0) or peripheral data enable, active low (io_mode 1) |

## Verification
The bench builds the block with its default ARB_DELAY of 2. This keeps the grant window short enough that random toggling of arb_en_n often lands inside the window as well as outside it. It therefore covers strobes that start late, strobes that drop in the middle of a cycle, and grants that come back before passive. Both strap values are run from reset. Random cycle lengths of one to five clocks cover cycles that end before the normal write strobe could start.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  localparam int STAT_W = 3;
  localparam logic [STAT_W-1:0] ST_PASSIVE = 3'b111;

  // command slot indices
  localparam int NCMD    = 7;
  localparam int C_MRD   = 0;
  localparam int C_MWR   = 1;
  localparam int C_IORD  = 2;
  localparam int C_IOWR  = 3;
  localparam int C_AMWR  = 4;
  localparam int C_AIOWR = 5;
  localparam int C_INTA  = 6;

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_ADDR = 2'd1, PH_EARLY = 2'd2, PH_LATE = 2'd3} phase_e;

  function automatic logic [NCMD-1:0] cmd_mask(input logic [STAT_W-1:0] code);
    logic [NCMD-1:0] m;
    m = '0;
    case (code)
      3'b000: m[C_INTA] = 1'b1;
      3'b001: m[C_IORD] = 1'b1;
      3'b010: begin m[C_IOWR] = 1'b1; m[C_AIOWR] = 1'b1; end
      3'b100, 3'b101: m[C_MRD] = 1'b1;
      3'b110: begin m[C_MWR] = 1'b1; m[C_AMWR] = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic bit is_late(input int idx);
    return (idx == C_MWR) || (idx == C_IOWR);
  endfunction

  function automatic bit is_io(input int idx);
    return (idx == C_IORD) || (idx == C_IOWR) || (idx == C_AIOWR) || (idx == C_INTA);
  endfunction

  function automatic logic is_read_code(input logic [STAT_W-1:0] code);
    return (code == 3'b000) || (code == 3'b001) || (code == 3'b100) || (code == 3'b101);
  endfunction

  function automatic logic is_io_code(input logic [STAT_W-1:0] code);
    return (code == 3'b000) || (code == 3'b001) || (code == 3'b010);
  endfunction

endpackage

// File: rtl/bcg_decode.sv
module bcg_decode
  import bcg_pkg::*;
(
  input  logic [STAT_W-1:0] code,
  output logic [NCMD-1:0]   mask,
  output logic              io_cyc
);
  always_comb begin
    mask   = cmd_mask(code);
    io_cyc = is_io_code(code);
  end
endmodule

// File: rtl/bcg_arb.sv
module bcg_arb #(
  parameter int ARB_DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arb_en_n,
  output logic grant
);
  localparam int CW = $clog2(ARB_DELAY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(ARB_DELAY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (arb_en_n)       cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign grant = (cnt_q == LIMIT);
endmodule

// File: rtl/bcg_seq.sv
module bcg_seq
  import bcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat_i,
  output logic [STAT_W-1:0] kind_q,
  output logic              ale_q,
  output logic              early,
  output logic              late
);
  phase_e phase_q;
  logic   passive;

  assign passive = (stat_i == ST_PASSIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      kind_q  <= ST_PASSIVE;
      ale_q   <= 1'b0;
    end else begin
      ale_q <= 1'b0;
      if (passive) begin
        phase_q <= PH_IDLE;
      end else begin
        case (phase_q)
          PH_IDLE: begin
            phase_q <= PH_ADDR;
            kind_q  <= stat_i;
            ale_q   <= 1'b1;
          end
          PH_ADDR:  phase_q <= PH_EARLY;
          default:  phase_q <= PH_LATE;
        endcase
      end
    end
  end

  assign early = !passive && (phase_q != PH_IDLE);
  assign late  = !passive && ((phase_q == PH_EARLY) || (phase_q == PH_LATE));
endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
  import bcg_pkg::*;
#(
  parameter int ARB_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              arb_en_n,
  input  logic              io_mode,
  input  logic              cmd_en,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic              adv_mem_wr_n,
  output logic              adv_io_wr_n,
  output logic              int_ack_n,
  output logic              addr_latch,
  output logic              dir_wr,
  output logic              data_en,
  output logic              casc_pden
);
  logic [STAT_W-1:0] kind_q;
  logic              early, late, grant, io_cyc;
  logic [NCMD-1:0]   mask, want, cmd_q;
  logic              any_want;
  logic              dir_q, den_q, pden_q, mce_q;

  bcg_seq u_seq (
    .clk(clk), .rst(rst), .stat_i(stat_i),
    .kind_q(kind_q), .ale_q(addr_latch), .early(early), .late(late)
  );

  bcg_arb #(.ARB_DELAY(ARB_DELAY)) u_arb (
    .clk(clk), .rst(rst), .arb_en_n(arb_en_n), .grant(grant)
  );

  bcg_decode u_dec (.code(kind_q), .mask(mask), .io_cyc(io_cyc));

  for (genvar g = 0; g < NCMD; g++) begin : g_cmd
    localparam bit LATE = is_late(g);
    localparam bit IOC  = is_io(g);
    assign want[g] = mask[g] && (LATE ? late : early)
                     && ((IOC && io_mode) || grant) && cmd_en;
    always_ff @(posedge clk) begin
      if (rst) cmd_q[g] <= 1'b0;
      else     cmd_q[g] <= want[g];
    end
  end

  assign any_want = |want;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= 1'b1;
      den_q  <= 1'b0;
      pden_q <= 1'b0;
      mce_q  <= 1'b0;
    end else begin
      dir_q  <= !((stat_i != ST_PASSIVE) && is_read_code(stat_i));
      den_q  <= any_want && !(io_mode && io_cyc);
      pden_q <= any_want && io_mode && io_cyc;
      mce_q  <= want[C_INTA] && !io_mode;
    end
  end

  assign mem_rd_n     = ~cmd_q[C_MRD];
  assign mem_wr_n     = ~cmd_q[C_MWR];
  assign io_rd_n      = ~cmd_q[C_IORD];
  assign io_wr_n      = ~cmd_q[C_IOWR];
  assign adv_mem_wr_n = ~cmd_q[C_AMWR];
  assign adv_io_wr_n  = ~cmd_q[C_AIOWR];
  assign int_ack_n    = ~cmd_q[C_INTA];
  assign dir_wr       = dir_q;
  assign data_en      = den_q;
  assign casc_pden    = io_mode ? ~pden_q : mce_q;
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk
  import bcg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [STAT_W-1:0] stat_i,
  input logic              arb_en_n,
  input logic              io_mode,
  input logic              cmd_en,
  input logic [NCMD-1:0]   cmd_act,
  input logic              grant,
  input logic              addr_latch,
  input logic              dir_wr,
  input logic              data_en
);
  p_rst_idle_r2: assert property (@(posedge clk)
    rst |=> (cmd_act == '0 && !addr_latch && !data_en && dir_wr));

  p_one_class_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_act[C_MRD], cmd_act[C_IORD], cmd_act[C_INTA],
              cmd_act[C_MWR] | cmd_act[C_AMWR], cmd_act[C_IOWR] | cmd_act[C_AIOWR]}));

  p_ale_single_r3: assert property (@(posedge clk) disable iff (rst)
    addr_latch |=> !addr_latch);

  p_adv_mem_lead_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_act[C_MWR] |-> cmd_act[C_AMWR]);

  p_adv_io_lead_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_act[C_IOWR] |-> cmd_act[C_AIOWR]);

  p_passive_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (stat_i == ST_PASSIVE) |=> (cmd_act == '0));

  p_sys_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (!io_mode && (|cmd_act)) |-> $past(grant));

  p_grant_drop_r6: assert property (@(posedge clk) disable iff (rst)
    arb_en_n |=> !grant);

  p_mem_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_act[C_MRD] | cmd_act[C_MWR] | cmd_act[C_AMWR]) |-> $past(grant));

  p_dir_write_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_act[C_MWR] | cmd_act[C_IOWR]) |-> dir_wr);

  p_dir_read_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_act[C_MRD] | cmd_act[C_IORD] | cmd_act[C_INTA]) |-> !dir_wr);

  p_den_cmd_r10: assert property (@(posedge clk) disable iff (rst)
    data_en |-> (|cmd_act));

  p_cen_block_r11: assert property (@(posedge clk) disable iff (rst)
    !cmd_en |=> (cmd_act == '0 && !data_en));
endmodule

bind bus_cmd_gen bcg_chk u_chk (
  .clk(clk), .rst(rst), .stat_i(stat_i), .arb_en_n(arb_en_n),
  .io_mode(io_mode), .cmd_en(cmd_en), .cmd_act(cmd_q), .grant(grant),
  .addr_latch(addr_latch), .dir_wr(dir_wr), .data_en(data_en)
);

// File: tb/bus_cmd_gen_tb.sv
module bus_cmd_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ARB = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] stat = 3'b111;
  logic aen_n = 1'b0, io_mode = 1'b0, cen = 1'b1;
  logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, adv_mem_wr_n, adv_io_wr_n, int_ack_n;
  logic addr_latch, dir_wr, data_en, casc_pden;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cmd_gen #(.ARB_DELAY(ARB)) u_dut (
    .clk(clk), .rst(rst), .stat_i(stat), .arb_en_n(aen_n), .io_mode(io_mode),
    .cmd_en(cen), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
    .io_wr_n(io_wr_n), .adv_mem_wr_n(adv_mem_wr_n), .adv_io_wr_n(adv_io_wr_n),
    .int_ack_n(int_ack_n), .addr_latch(addr_latch), .dir_wr(dir_wr),
    .data_en(data_en), .casc_pden(casc_pden)
  );

  // expected command bits: [0]mrd [1]mwr [2]iord [3]iowr [4]amw [5]aiow [6]inta
  function automatic logic [6:0] exp_cmds(input logic [2:0] c, input bit e, input bit l,
                                          input bit gi, input bit gm, input bit en);
    logic [6:0] r;
    r = '0;
    case (c)
      3'd0: r[6] = e && gi;
      3'd1: r[2] = e && gi;
      3'd2: begin r[5] = e && gi; r[3] = l && gi; end
      3'd4, 3'd5: r[0] = e && gm;
      3'd6: begin r[4] = e && gm; r[1] = l && gm; end
      default: r = '0;
    endcase
    return en ? r : 7'd0;
  endfunction

  int m_phase = 0, m_cnt = 0;
  logic [6:0] e_cmd = '0;
  logic e_ale = 1'b0, e_dir = 1'b1, e_den = 1'b0, e_pden = 1'b0, e_mce = 1'b0;

  always @(posedge clk) begin : model
    bit pas, ea, la, gm, gi, ioc;
    logic [6:0] w;
    if (rst) begin
      m_phase = 0; m_cnt = 0; e_cmd = '0; e_ale = 0; e_dir = 1; e_den = 0; e_pden = 0; e_mce = 0;
    end else begin
      pas = (stat == 3'b111);
      ea  = !pas && m_phase >= 1;
      la  = !pas && m_phase >= 2;
      gm  = (m_cnt >= ARB);
      gi  = io_mode || gm;
      ioc = (stat <= 3'd2);
      w   = exp_cmds(stat, ea, la, gi, gm, cen);
      e_cmd  = w;
      e_ale  = !pas && m_phase == 0;
      e_dir  = !(!pas && (stat == 0 || stat == 1 || stat == 4 || stat == 5));
      e_den  = (|w) && !(io_mode && ioc);
      e_pden = (|w) && io_mode && ioc;
      e_mce  = w[6] && !io_mode;
      if (pas) m_phase = 0; else if (m_phase < 3) m_phase = m_phase + 1;
      if (aen_n) m_cnt = 0; else if (m_cnt < ARB) m_cnt = m_cnt + 1;
    end
  end

  task automatic chk(input string tag, input string dflt, input string name,
                     input logic act, input logic exp);
    string t;
    t = (tag == "") ? dflt : tag;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", t, name, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "R4", "mem_rd_n", mem_rd_n, !e_cmd[0]);
    chk(tag, "R4", "mem_wr_n", mem_wr_n, !e_cmd[1]);
    chk(tag, "R4", "io_rd_n", io_rd_n, !e_cmd[2]);
    chk(tag, "R4", "io_wr_n", io_wr_n, !e_cmd[3]);
    chk(tag, "R4", "adv_mem_wr_n", adv_mem_wr_n, !e_cmd[4]);
    chk(tag, "R4", "adv_io_wr_n", adv_io_wr_n, !e_cmd[5]);
    chk(tag, "R1", "int_ack_n", int_ack_n, !e_cmd[6]);
    chk(tag, "R3", "addr_latch", addr_latch, e_ale);
    chk(tag, "R9", "dir_wr", dir_wr, e_dir);
    chk(tag, "R10", "data_en", data_en, e_den);
    chk(tag, "R8", "casc_pden", casc_pden, io_mode ? !e_pden : e_mce);
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic run_cycle(input string tag, input logic [2:0] code, input int hold, input int idle);
    stat = code;
    repeat (hold) tick(tag);
    stat = 3'b111;
    repeat (idle) tick(tag);
  endtask

  task automatic do_reset(input bit strap, input string tag);
    @(negedge clk);
    rst = 1; io_mode = strap; stat = 3'b111;
    repeat (2) tick(tag);
    rst = 0;
  endtask

  task automatic random_run(input int n);
    int hold, idle;
    hold = 0; idle = 1;
    for (int i = 0; i < n; i++) begin
      tick("");
      aen_n = ($urandom_range(0, 5) == 0);
      cen   = ($urandom_range(0, 15) != 0);
      if (hold > 0) begin
        hold--;
        if (hold == 0) begin stat = 3'b111; idle = $urandom_range(1, 3); end
      end else if (idle > 1) begin
        idle--;
      end else begin
        stat = 3'($urandom_range(0, 6));
        hold = $urandom_range(1, 5);
      end
    end
    stat = 3'b111;
    tick("");
  endtask

  initial begin
    void'($urandom(32'd1234));
    // reset state, both straps (R2)
    @(negedge clk); @(negedge clk);
    check_all("R2");
    do_reset(1'b1, "R2");
    do_reset(1'b0, "R2");
    // decode table with grant held (R1)
    aen_n = 0; cen = 1;
    repeat (3) tick("R1");
    for (int c = 0; c < 7; c++) run_cycle("R1", 3'(c), 4, 2);
    // halt (R12) and return to passive mid-cycle (R5)
    run_cycle("R12", 3'b011, 4, 2);
    run_cycle("R5", 3'b110, 2, 2);
    run_cycle("R5", 3'b010, 1, 2);
    // system-bus wait and mid-cycle drop (R6)
    aen_n = 1; stat = 3'b101;
    repeat (3) tick("R6");
    aen_n = 0;
    repeat (4) tick("R6");
    aen_n = 1;
    repeat (2) tick("R6");
    aen_n = 0;
    run_cycle("R6", 3'b101, 0, 2);
    // I/O-bus mode: I/O free, memory waits (R7)
    do_reset(1'b1, "R2");
    aen_n = 1;
    run_cycle("R7", 3'b001, 4, 2);
    run_cycle("R7", 3'b010, 4, 2);
    run_cycle("R7", 3'b000, 4, 2);
    run_cycle("R7", 3'b110, 4, 2);
    run_cycle("R8", 3'b000, 3, 1);
    // command enable low (R11)
    aen_n = 0; cen = 0;
    run_cycle("R11", 3'b001, 4, 2);
    run_cycle("R11", 3'b110, 4, 2);
    cen = 1;
    // random, both straps
    do_reset(1'b0, "R2");
    random_run(3000);
    do_reset(1'b1, "R2");
    random_run(3000);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule